// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a bus-attached watchdog that runs in two chained stages. When software arms it, a first stage counts coarse ticks and, when the count runs out, raises a pretimeout interrupt. A second stage then starts counting. If software does not kick the watchdog before this second stage runs out, the block issues a one-cycle reset request on one of three outputs. Each output drives a different reset target. Once the first stage has fired, clearing the enable bit no longer stops the timer.

Ticks come from a free-running prescaler. Its period is 2^BASE_EXP bus clock cycles, multiplied by 1, 2, 4 or 8 as chosen by a two-bit scale field. Software uses a simple single-cycle register bus. A write strobe updates a register on the same clock edge. A read strobe returns the addressed register on `rdata` after that edge.

The phase state machine has four states: ST_IDLE, ST_PH1, ST_PH2 and ST_DONE. Its transitions are:
- arm (ST_IDLE to ST_PH1 when enable is set);
- stop (ST_PH1 to ST_IDLE when enable is cleared);
- kick (ST_PH1 or ST_PH2 to ST_PH1, with the count cleared);
- pretimeout (ST_PH1 to ST_PH2);
- expire (ST_PH2 to ST_DONE);
- release (ST_DONE to ST_IDLE when enable is cleared).

Top module: `phase_watchdog`

## Requirements
- R1: A tick occurs every 2^(BASE_EXP+S) clock cycles while the timer runs, where S is the scale field (0..3). The prescaler restarts from zero on arm and on every kick.
- R2: Word address 0 is the kick register and reads 0. Word address 1 is status. Word address 2 is control, laid out as: bit 31 enable, bits 30:29 scale, bits 26:22 first-stage limit, bits 19:15 second-stage limit, bits 1:0 reset target. Other control bits read 0. After reset, control reads 0x00000001 and status reads 0.
- R3: After enable is written, the first stage expires after (L1+1) ticks, where L1 is the first-stage limit. At that point status bit 31 is set, `irq` goes high, and the second stage begins.
- R4: The second stage expires after (L2+1) ticks, where L2 is the second-stage limit. At that point status bit 30 is set and a reset request is issued.
- R5: The reset request is a one-cycle pulse, selected by the reset-target field: 0 pulses `rst_soc`, 1 pulses `rst_cpu`, 2 pulses `rst_sw`, and 3 pulses nothing. At most one reset output is high at any time.
- R6: Writing a word with bit 31 = 1 to address 0 during either stage returns the timer to the first stage with a count of zero. A write with bit 31 = 0, or a kick while idle, has no effect.
- R7: Status bits are write-1-to-clear, and bits written as 0 are kept. `irq` equals status bit 31.
- R8: Clearing enable before the first stage expires stops the timer. Re-arming it then starts a full first stage from zero.
- R9: Once the first stage has expired, clearing enable does not stop the second stage or its reset request.
- R10: After a reset request, the timer stays halted with no further requests until enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid after the read edge |
| irq | output | 1 | Pretimeout interrupt (status bit 31) |
| rst_soc | output | 1 | Full-chip reset request pulse |
| rst_cpu | output | 1 | Processor-only reset request pulse |
| rst_sw | output | 1 | Software reset request pulse |

## Verification
The hardest case to reach from the ports is a kick or an enable clear that lands in the second stage. It needs a precisely timed first-stage expiry followed by a register write before the reset fires. The bench scales the prescaler down to 2^2 cycles and derives the exact expiry edge from the limits it programmed. It then places directed kicks and enable clears inside the second stage, and checks the resulting reset request to the cycle. Randomised trials vary the scale, both limits and the reset target, and every edge is predicted by bench functions.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
    localparam int SCALE_W = 2;
    localparam int LIM_W   = 5;

    // word addresses
    localparam logic [1:0] ADR_KICK = 2'd0;
    localparam logic [1:0] ADR_STS  = 2'd1;
    localparam logic [1:0] ADR_CTL  = 2'd2;

    // field positions, decoded by software
    localparam int CTL_EN_BIT    = 31;
    localparam int CTL_SCALE_LSB = 29;
    localparam int CTL_L1_LSB    = 22;
    localparam int CTL_L2_LSB    = 15;
    localparam int STS_P1_BIT    = 31;
    localparam int STS_P2_BIT    = 30;

    localparam logic [1:0] TGT_SOC  = 2'd0;
    localparam logic [1:0] TGT_CPU  = 2'd1;
    localparam logic [1:0] TGT_SW   = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PH1,
        ST_PH2,
        ST_DONE
    } pwd_state_e;
endpackage

// File: rtl/pwd_tick_gen.sv
module pwd_tick_gen #(
    parameter int BASE_EXP = 25,
    parameter int SCALE_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick
);
    localparam int PRE_W = BASE_EXP + (2**SCALE_W) - 1;
    localparam logic [PRE_W-1:0]   PRE_ONES  = '1;
    localparam logic [SCALE_W-1:0] SCALE_TOP = '1;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = PRE_ONES >> (SCALE_TOP - scale);
        tick  = run && (pre >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre <= '0;
        else if (!run || restart || tick)
            pre <= '0;
        else
            pre <= pre + 1'b1;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick); // R8
endmodule

// File: rtl/pwd_phase_fsm.sv
module pwd_phase_fsm
    import pwd_pkg::*;
#(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          kick,
    input  logic          tick,
    input  logic [LW-1:0] lim1,
    input  logic [LW-1:0] lim2,
    input  logic [1:0]    target,
    output logic          run,
    output logic          locked,
    output logic          p1_fire,
    output logic          p2_fire,
    output logic          rst_soc,
    output logic          rst_cpu,
    output logic          rst_sw
);
    pwd_state_e state, nxt;
    logic [LW-1:0] cnt;
    logic          clr, inc;

    always_comb begin
        nxt     = state;
        clr     = 1'b0;
        inc     = 1'b0;
        p1_fire = 1'b0;
        p2_fire = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (enable) begin
                    nxt = ST_PH1;
                    clr = 1'b1;
                end
            end
            ST_PH1: begin
                if (!enable) begin
                    nxt = ST_IDLE;
                    clr = 1'b1;
                end else if (kick) begin
                    clr = 1'b1;
                end else if (tick) begin
                    if (cnt == lim1) begin
                        nxt     = ST_PH2;
                        clr     = 1'b1;
                        p1_fire = 1'b1;
                    end else begin
                        inc = 1'b1;
                    end
                end
            end
            ST_PH2: begin
                if (kick) begin
                    nxt = ST_PH1;
                    clr = 1'b1;
                end else if (tick) begin
                    if (cnt == lim2) begin
                        nxt     = ST_DONE;
                        clr     = 1'b1;
                        p2_fire = 1'b1;
                    end else begin
                        inc = 1'b1;
                    end
                end
            end
            ST_DONE: begin
                if (!enable)
                    nxt = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (clr)
                cnt <= '0;
            else if (inc)
                cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_soc <= 1'b0;
            rst_cpu <= 1'b0;
            rst_sw  <= 1'b0;
        end else begin
            rst_soc <= p2_fire && (target == TGT_SOC);
            rst_cpu <= p2_fire && (target == TGT_CPU);
            rst_sw  <= p2_fire && (target == TGT_SW);
        end
    end

    assign run    = (state == ST_PH1) || (state == ST_PH2);
    assign locked = (state == ST_PH2);

    AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PH2 && !enable && !kick) |=> (state != ST_IDLE)); // R9
    AST_KICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && run && enable) |=> (state == ST_PH1)); // R6
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_DONE || state == ST_IDLE)); // R10
endmodule

// File: rtl/phase_watchdog.sv
module phase_watchdog
    import pwd_pkg::*;
#(
    parameter int BASE_EXP = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    output logic        rst_soc,
    output logic        rst_cpu,
    output logic        rst_sw
);
    logic               c_en;
    logic [SCALE_W-1:0] c_scale;
    logic [LIM_W-1:0]   c_l1, c_l2;
    logic [1:0]         c_tgt;
    logic               s_p1, s_p2;
    logic               kick, tick, run, locked, p1_fire, p2_fire;
    logic [31:0]        ctl_word;
    logic               wdata_unused;

    assign kick = wr_en && (addr == ADR_KICK) && wdata[31];
    assign wdata_unused = ^{wdata[28:27], wdata[21:20], wdata[14:2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_en    <= 1'b0;
            c_scale <= '0;
            c_l1    <= '0;
            c_l2    <= '0;
            c_tgt   <= TGT_CPU;
        end else if (wr_en && addr == ADR_CTL) begin
            c_en    <= wdata[CTL_EN_BIT];
            c_scale <= wdata[CTL_SCALE_LSB +: SCALE_W];
            c_l1    <= wdata[CTL_L1_LSB +: LIM_W];
            c_l2    <= wdata[CTL_L2_LSB +: LIM_W];
            c_tgt   <= wdata[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_p1 <= 1'b0;
            s_p2 <= 1'b0;
        end else begin
            s_p1 <= p1_fire || (s_p1 && !(wr_en && addr == ADR_STS && wdata[STS_P1_BIT]));
            s_p2 <= p2_fire || (s_p2 && !(wr_en && addr == ADR_STS && wdata[STS_P2_BIT]));
        end
    end

    always_comb begin
        ctl_word = '0;
        ctl_word[CTL_EN_BIT]                = c_en;
        ctl_word[CTL_SCALE_LSB +: SCALE_W]  = c_scale;
        ctl_word[CTL_L1_LSB +: LIM_W]       = c_l1;
        ctl_word[CTL_L2_LSB +: LIM_W]       = c_l2;
        ctl_word[1:0]                       = c_tgt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en) begin
            case (addr)
                ADR_STS: rdata <= {s_p1, s_p2, 30'd0};
                ADR_CTL: rdata <= ctl_word;
                default: rdata <= '0;
            endcase
        end
    end

    pwd_tick_gen #(.BASE_EXP(BASE_EXP), .SCALE_W(SCALE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(kick),
        .scale(c_scale), .tick(tick)
    );

    pwd_phase_fsm #(.LW(LIM_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(c_en), .kick(kick), .tick(tick),
        .lim1(c_l1), .lim2(c_l2), .target(c_tgt),
        .run(run), .locked(locked), .p1_fire(p1_fire), .p2_fire(p2_fire),
        .rst_soc(rst_soc), .rst_cpu(rst_cpu), .rst_sw(rst_sw)
    );

    assign irq = s_p1;

    AST_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_soc, rst_cpu, rst_sw})); // R5
    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_soc || rst_cpu || rst_sw) |=> !(rst_soc || rst_cpu || rst_sw)); // R5
    AST_IRQ_ENTERS_PH2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> locked); // R3
endmodule

// File: tb/phase_watchdog_tb.sv
module phase_watchdog_tb;
    localparam int BE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rst_soc, rst_cpu, rst_sw;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    always #5 clk = ~clk;

    phase_watchdog #(.BASE_EXP(BE)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq),
        .rst_soc(rst_soc), .rst_cpu(rst_cpu), .rst_sw(rst_sw)
    );

    always @(posedge clk) if (rst_soc || rst_cpu || rst_sw) pulses++;

    function automatic int tick_len(int sc);
        return 1 << (BE + sc);
    endfunction

    function automatic int stage_cycles(int sc, int lim);
        return (lim + 1) * tick_len(sc);
    endfunction

    function automatic logic [31:0] cw(bit en, int sc, int l1, int l2, int tg);
        return {en, 2'(sc), 2'b00, 5'(l1), 2'b00, 5'(l2), 13'd0, 2'(tg)};
    endfunction

    function automatic logic [2:0] exp_rst(int tg);
        case (tg)
            0: return 3'b100;
            1: return 3'b010;
            2: return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int unsigned seed_v;
        int sc, l1, l2, tg, n1, n2, p0;
        seed_v = $urandom(32'd7719);

        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R2 irq after reset", {31'd0, irq}, 32'd0);
        chk("R5 reset outputs idle", {29'd0, rst_soc, rst_cpu, rst_sw}, 32'd0);
        rd(2'd2, v); chk("R2 control reset value", v, 32'h0000_0001);
        rd(2'd1, v); chk("R2 status reset value", v, 32'h0);
        rd(2'd0, v); chk("R2 kick register reads 0", v, 32'h0);

        // control readback of random words
        for (int k = 0; k < 4; k++) begin
            logic [31:0] w;
            w = $urandom() & 32'h7FFF_FFFF;
            wr(2'd2, w);
            rd(2'd2, v); chk("R2 control field readback", v, w & 32'hE7CF_8003);
        end
        wr(2'd2, 32'h0);

        // randomised full runs, every target value visited
        for (int t = 0; t < 8; t++) begin
            sc = $urandom() % 4; l1 = $urandom() % 8; l2 = $urandom() % 8; tg = t % 4;
            n1 = stage_cycles(sc, l1); n2 = stage_cycles(sc, l2);
            wr(2'd2, cw(1, sc, l1, l2, tg));
            wait_n(n1);
            chk("R1 R3 no pretimeout one cycle early", {31'd0, irq}, 32'd0);
            wait_n(1);
            chk("R1 R3 pretimeout on time", {31'd0, irq}, 32'd1);
            rd(2'd1, v); chk("R3 status bit 31 set", v, 32'h8000_0000);
            p0 = pulses;
            wait_n(n2 - 2);
            chk("R4 no reset before second stage ends", pulses, p0);
            wait_n(1);
            chk("R4 R5 reset target pulse", {29'd0, rst_soc, rst_cpu, rst_sw}, {29'd0, exp_rst(tg)});
            wait_n(1);
            chk("R5 reset pulse lasts one cycle", {29'd0, rst_soc, rst_cpu, rst_sw}, 32'd0);
            rd(2'd1, v); chk("R4 status bits 31 and 30", v, 32'hC000_0000);
            p0 = pulses;
            wait_n(3 * n2 + 8);
            chk("R10 halted after reset request", pulses, p0);
            wr(2'd2, cw(0, sc, l1, l2, tg));
            wr(2'd1, 32'hC000_0000);
            rd(2'd1, v); chk("R7 status cleared by write-one", v, 32'h0);
            chk("R7 irq follows status", {31'd0, irq}, 32'd0);
        end

        // directed: scale 0, limits 5 and 3, cpu target
        n1 = stage_cycles(0, 5); n2 = stage_cycles(0, 3);

        // kick write with bit 31 clear has no effect
        wr(2'd2, cw(1, 0, 5, 3, 1));
        wait_n(4);
        wr(2'd0, 32'h7FFF_FFFF);
        wait_n(n1 - 5);
        chk("R6 bit31=0 kick ignored, irq still low", {31'd0, irq}, 32'd0);
        wait_n(1);
        chk("R6 bit31=0 kick ignored, original timing", {31'd0, irq}, 32'd1);

        // kick in second stage returns to first stage
        p0 = pulses;
        wr(2'd0, 32'h8000_0000);
        wr(2'd1, 32'h8000_0000);
        wait_n(n1 - 2);
        chk("R6 kick in stage two cancels reset", pulses, p0);
        chk("R6 first stage rerun, irq low", {31'd0, irq}, 32'd0);
        wait_n(1);
        chk("R6 first stage rerun from zero", {31'd0, irq}, 32'd1);

        // lockout: clearing enable in stage two does not stop it
        wr(2'd2, cw(0, 0, 5, 3, 1));
        wait_n(n2 - 2);
        chk("R9 no reset yet", pulses, p0);
        wait_n(1);
        chk("R9 reset despite enable clear", {29'd0, rst_soc, rst_cpu, rst_sw}, 32'd2);

        // partial write-one-to-clear
        wr(2'd1, 32'h4000_0000);
        rd(2'd1, v); chk("R7 zero bits keep status", v, 32'h8000_0000);
        chk("R7 irq kept high", {31'd0, irq}, 32'd1);
        wr(2'd1, 32'h8000_0000);
        rd(2'd1, v); chk("R7 bit 31 cleared", v, 32'h0);
        chk("R7 irq dropped", {31'd0, irq}, 32'd0);

        // kick inside first stage
        wr(2'd2, cw(1, 0, 5, 3, 1));
        wait_n(10);
        wr(2'd0, 32'h8000_0000);
        wait_n(n1 - 1);
        chk("R6 kick in stage one, irq low", {31'd0, irq}, 32'd0);
        wait_n(1);
        chk("R6 kick in stage one restarts count", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h8000_0000);
        wr(2'd2, cw(0, 0, 5, 3, 1));
        wr(2'd1, 32'hC000_0000);

        // disable before stage one expires
        p0 = pulses;
        wr(2'd2, cw(1, 0, 5, 3, 1));
        wait_n(15);
        wr(2'd2, cw(0, 0, 5, 3, 1));
        wait_n(200);
        chk("R8 stopped timer raises no irq", {31'd0, irq}, 32'd0);
        chk("R8 stopped timer issues no reset", pulses, p0);
        rd(2'd1, v); chk("R8 status untouched while stopped", v, 32'h0);
        wr(2'd2, cw(1, 0, 5, 3, 1));
        wait_n(n1);
        chk("R8 re-arm runs full stage, irq low", {31'd0, irq}, 32'd0);
        wait_n(1);
        chk("R8 re-arm expires on time", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h8000_0000);
        wr(2'd2, cw(0, 0, 5, 3, 1));
        wr(2'd1, 32'hC000_0000);

        // kick while idle has no effect
        wr(2'd0, 32'h8000_0000);
        wait_n(100);
        chk("R6 kick while idle ignored", {31'd0, irq}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule